// File: doc/BRIEF.md
# Presence-Detect EEPROM Serial Slave

This block answers on a two-wire serial bus (clock line plus bidirectional data line) and serves a 256-byte table that describes a memory module. The bus lines are sampled with the system clock, so the block can sit in the core clock domain. The data line is driven only through an active-high pull-down enable; the pad itself lives outside the block. A host addresses the block with a 7-bit device address: the fixed prefix `1010` followed by three strap inputs. The host can then set the byte pointer, read one byte or a run of bytes, or write a single byte.

The array has two halves. The lower half (bytes 0 to 127) holds the factory description and cannot be rewritten. The upper half (bytes 128 to 255) is free for user data, unless the write-protect input is high. Byte 63 holds a checksum of bytes 0 to 62. A helper output is high whenever the stored checksum matches the bytes it covers.

Top module: `pd_eeprom_slave`

## Requirements
- R1: The block acknowledges (pulls the data line low in the ninth clock) a device byte whose upper seven bits equal `1010` followed by strap bits 2, 1, 0. Any other device byte gets no acknowledge, and the block stays silent until the next start condition. Bit 0 of the device byte selects read (1) or write (0).
- R2: A write-mode device byte followed by an address byte loads the byte pointer. A repeated start and a read-mode device byte then return the byte stored at that address, most significant bit first.
- R3: During a read, each byte the host acknowledges advances the pointer by one, and the next byte follows. The pointer wraps from 255 to 0. A byte the host does not acknowledge ends the read.
- R4: A data byte written to an address of 128 or above, with write-protect low, is acknowledged and is stored.
- R5: A data byte written to an address below 128 is acknowledged, but the stored byte does not change.
- R6: A data byte written while write-protect is high is acknowledged, but no byte changes.
- R7: After reset the table reads as follows. Byte 0 is 0x80 and byte 1 is 0x08. Byte i for 2 to 62 is (37*i + 11) mod 256. Byte 63 is the checksum. Byte i for 64 to 127 is i XOR 0x5A. Every byte from 128 to 255 is 0xFF.
- R8: `csum_ok_o` is high exactly when byte 63 equals the low 8 bits of the sum of bytes 0 to 62.
- R9: A write carries one data byte. A second data byte in the same transfer is not acknowledged and is not stored. After the write, the pointer sits one past the written address, so a read that sends no address returns the next byte.
- R10: The data-line enable changes only after the clock line has been seen low, or when a start or stop condition occurs. A stop condition always releases the data line.
- R11: While reset is applied, and right after it, the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level, as seen on the wire |
| sda_oe_o | output | 1 | High pulls the data line low |
| strap_i | input | 3 | Device address strap bits 2..0 |
| wp_i | input | 1 | Write protect, high blocks every write |
| csum_ok_o | output | 1 | Stored checksum matches bytes 0 to 62 |

## Verification
The write-acknowledge of a data byte and the commit of that byte to the array happen in the same transition, and the lock and protect gating must drop the commit without dropping the acknowledge. The bench provokes this with writes to both halves, with write-protect high and low. It judges each case twice: by the acknowledge bit it samples on the wire, and by a later random read of the same address. The checksum helper is watched throughout, so that a commit which slips past the lower-half lock would also show up as a falling `csum_ok_o`.

// File: rtl/pd_eeprom_pkg.sv
`timescale 1ns/1ps
package pd_eeprom_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK,
    ST_HOLD
  } twi_state_e;

  // Content of a description byte that the checksum covers
  function automatic logic [7:0] desc_byte(input logic [31:0] idx);
    logic [31:0] mix;
    if (idx == 32'd0) return 8'h80;
    if (idx == 32'd1) return 8'h08;
    mix = idx * 32'd37 + 32'd11;
    return mix[7:0];
  endfunction

  // Reset image of the whole array
  function automatic logic [7:0] image_byte(input logic [31:0] idx,
                                            input logic [31:0] depth,
                                            input logic [31:0] csum_idx);
    logic [7:0] sum;
    if (idx < csum_idx) return desc_byte(idx);
    if (idx == csum_idx) begin
      sum = '0;
      for (logic [31:0] j = 0; j < csum_idx; j++) sum = sum + desc_byte(j);
      return sum;
    end
    if (idx < (depth >> 1)) return idx[7:0] ^ 8'h5A;
    return 8'hFF;
  endfunction

endpackage

// File: rtl/pd_rst_sync.sv
`timescale 1ns/1ps
module pd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/pd_pin_sync.sv
`timescale 1ns/1ps
module pd_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int unsigned NPIN = 2;

  logic [NPIN-1:0] pin_raw;
  logic [NPIN-1:0] pin_now;
  logic [NPIN-1:0] pin_old;

  assign pin_raw = {sda_i, scl_i};

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [STAGES:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= {pipe_q[STAGES-1:0], pin_raw[p]};
    end
    assign pin_now[p] = pipe_q[STAGES-1];
    assign pin_old[p] = pipe_q[STAGES];
  end

  assign sda_lvl   = pin_now[1];
  assign scl_rise  = pin_now[0] & ~pin_old[0];
  assign scl_fall  = ~pin_now[0] & pin_old[0];
  assign start_det = pin_now[0] & pin_old[0] & pin_old[1] & ~pin_now[1];
  assign stop_det  = pin_now[0] & pin_old[0] & ~pin_old[1] & pin_now[1];

endmodule

// File: rtl/pd_twi_fsm.sv
`timescale 1ns/1ps
module pd_twi_fsm
  import pd_eeprom_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter logic [3:0]  DEV_PREFIX = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        strap,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] ptr,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_data
);

  localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);
  localparam logic [3:0] FULL_CNT = 4'(BYTE_W);

  twi_state_e        state_q, state_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              oe_q, oe_d;
  logic              rw_q, rw_d;
  logic              mack_q, mack_d;
  logic              wr_stb_q, wr_stb_d;
  logic              byte_full;
  logic              dev_hit;

  assign byte_full = (cnt_q == FULL_CNT);
  assign dev_hit   = (shreg_q[BYTE_W-1:1] == {DEV_PREFIX, strap});

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    shreg_d  = shreg_q;
    ptr_d    = ptr_q;
    oe_d     = oe_q;
    rw_d     = rw_q;
    mack_d   = mack_q;
    wr_stb_d = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_DEV;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (scl_rise && !byte_full) begin
            shreg_d = {shreg_q[BYTE_W-2:0], sda_lvl};
            cnt_d   = cnt_q + 4'd1;
          end else if (scl_fall && byte_full) begin
            cnt_d = '0;
            if (state_q == ST_DEV) begin
              if (dev_hit) begin
                oe_d    = 1'b1;
                rw_d    = shreg_q[0];
                state_d = ST_DEV_ACK;
              end else begin
                state_d = ST_HOLD;
              end
            end else if (state_q == ST_WADR) begin
              ptr_d   = shreg_q[ADDR_W-1:0];
              oe_d    = 1'b1;
              state_d = ST_WADR_ACK;
            end else begin
              wr_stb_d = 1'b1;
              oe_d     = 1'b1;
              state_d  = ST_WDAT_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              shreg_d = rd_data;
              oe_d    = ~rd_data[BYTE_W-1];
              state_d = ST_RDAT;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_WADR;
            end
          end
        end
        ST_WADR_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            state_d = ST_WDAT;
          end
        end
        ST_WDAT_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            ptr_d   = ptr_q + 1'b1;
            state_d = ST_HOLD;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              oe_d    = 1'b0;
              ptr_d   = ptr_q + 1'b1;
              state_d = ST_RACK;
            end else begin
              shreg_d = {shreg_q[BYTE_W-2:0], 1'b0};
              oe_d    = ~shreg_q[BYTE_W-2];
              cnt_d   = cnt_q + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              shreg_d = rd_data;
              oe_d    = ~rd_data[BYTE_W-1];
              cnt_d   = '0;
              state_d = ST_RDAT;
            end else begin
              state_d = ST_HOLD;
            end
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      shreg_q  <= '0;
      ptr_q    <= '0;
      oe_q     <= 1'b0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      wr_stb_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      shreg_q  <= shreg_d;
      ptr_q    <= ptr_d;
      oe_q     <= oe_d;
      rw_q     <= rw_d;
      mack_q   <= mack_d;
      wr_stb_q <= wr_stb_d;
    end
  end

  assign sda_oe  = oe_q;
  assign ptr     = ptr_q;
  assign wr_stb  = wr_stb_q;
  assign wr_data = shreg_q;

endmodule

// File: rtl/pd_store.sv
`timescale 1ns/1ps
module pd_store
  import pd_eeprom_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned CSUM_IDX = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              wp,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic              csum_ok
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] cell_q [DEPTH];
  logic [BYTE_W-1:0] csum_acc;
  logic              wr_en;

  // only the upper half accepts data, and only with protect low
  assign wr_en = wr_stb & ~wp & ptr[ADDR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int unsigned i = 0; i < DEPTH; i++)
        cell_q[i] <= image_byte(32'(i), 32'(DEPTH), 32'(CSUM_IDX));
    end else if (wr_en) begin
      cell_q[ptr] <= wr_data;
    end
  end

  assign rd_data = cell_q[ptr];

  always_comb begin
    csum_acc = '0;
    for (int unsigned j = 0; j < CSUM_IDX; j++) csum_acc = csum_acc + cell_q[j];
  end

  assign csum_ok = (csum_acc == cell_q[CSUM_IDX]);

endmodule

// File: rtl/pd_eeprom_slave.sv
`timescale 1ns/1ps
module pd_eeprom_slave
  import pd_eeprom_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned CSUM_IDX    = 63,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [3:0]  DEV_PREFIX  = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       csum_ok_o
);

  logic              rst_n_s;
  logic              sda_lvl;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic [ADDR_W-1:0] ptr;
  logic              wr_stb;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] rd_data;

  pd_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  pd_pin_sync #(.STAGES(SYNC_STAGES)) i_pin_sync (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  pd_twi_fsm #(.ADDR_W(ADDR_W), .DEV_PREFIX(DEV_PREFIX)) i_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .strap     (strap_i),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe_o),
    .ptr       (ptr),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data)
  );

  pd_store #(.ADDR_W(ADDR_W), .CSUM_IDX(CSUM_IDX)) i_store (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_stb  (wr_stb),
    .wp      (wp_i),
    .ptr     (ptr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .csum_ok (csum_ok_o)
  );

endmodule

// File: rtl/pd_eeprom_chk.sv
`timescale 1ns/1ps
module pd_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det,
  input logic wr_stb,
  input logic csum_ok
);

  // R10
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R4
  wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> sda_oe);

  // R9
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R8
  csum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csum_ok |=> csum_ok);

endmodule

bind pd_eeprom_slave pd_eeprom_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .sda_oe    (sda_oe_o),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .wr_stb    (wr_stb),
  .csum_ok   (csum_ok_o)
);

// File: tb/test_pd_eeprom_slave.sv
`timescale 1ns/1ps
module test_pd_eeprom_slave;

  localparam int Q    = 8;
  localparam int NVEC = 12;
  // {wp, op (0 write, 1 random read), address, data}
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 8'h90, 8'h3C},
    {1'b0, 2'd1, 8'h90, 8'h00},
    {1'b0, 2'd0, 8'h10, 8'h00},
    {1'b0, 2'd1, 8'h10, 8'h00},
    {1'b1, 2'd0, 8'hA0, 8'h77},
    {1'b0, 2'd1, 8'hA0, 8'h00},
    {1'b0, 2'd0, 8'hFF, 8'h81},
    {1'b0, 2'd1, 8'hFF, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'h00},
    {1'b0, 2'd1, 8'h01, 8'h00},
    {1'b1, 2'd0, 8'h20, 8'h55},
    {1'b0, 2'd0, 8'h80, 8'hC3}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl;
  logic       sda_m;
  logic       sda_oe;
  logic       csum_ok;
  logic [2:0] strap;
  logic       wp;
  logic       sda_bus;
  logic [7:0] model [256];
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  pd_eeprom_slave i_pd_eeprom_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_bus),
    .sda_oe_o  (sda_oe),
    .strap_i   (strap),
    .wp_i      (wp),
    .csum_ok_o (csum_ok)
  );

  function automatic logic [7:0] img(input int i);
    logic [7:0] s;
    int         t;
    if (i == 0) return 8'h80;
    if (i == 1) return 8'h08;
    if (i < 63) begin t = (37 * i + 11) % 256; return 8'(t); end
    if (i == 63) begin
      s = 8'h80 + 8'h08;
      for (int k = 2; k < 63; k++) s = s + 8'((37 * k + 11) % 256);
      return s;
    end
    if (i < 128) return 8'(i) ^ 8'h5A;
    return 8'hFF;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hp();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hp(); scl = 1'b1; hp(); sda_m = 1'b0; hp(); scl = 1'b0; hp();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp(); scl = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp(); scl = 1'b1; hp(); scl = 1'b0; hp();
    end
    sda_m = 1'b1; hp(); scl = 1'b1; hp(); ack = sda_bus; scl = 1'b0; hp();
  endtask

  task automatic rx_byte(input logic host_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b1; hp(); b[i] = sda_bus; scl = 1'b0; hp();
    end
    sda_m = ~host_ack; hp(); scl = 1'b1; hp(); scl = 1'b0; hp(); sda_m = 1'b1;
  endtask

  // address phase of a random read, leaves the block ready to send data
  task automatic read_setup(input logic [6:0] dev, input logic [7:0] a, input string tag);
    logic ak;
    bus_start();
    tx_byte({dev, 1'b0}, ak); chk({tag, " dev-w ack"}, ak, 0);
    tx_byte(a, ak);           chk({tag, " addr ack"}, ak, 0);
    bus_start();
    tx_byte({dev, 1'b1}, ak); chk({tag, " dev-r ack"}, ak, 0);
  endtask

  task automatic rand_read(input logic [7:0] a, input string tag);
    logic [7:0] b;
    read_setup(7'h55, a, tag);
    rx_byte(1'b0, b);
    bus_stop();
    chk({tag, " data"}, b, model[a]);
  endtask

  task automatic byte_write(input logic [7:0] a, input logic [7:0] d, input string tag);
    logic ak;
    bus_start();
    tx_byte(8'hAA, ak); chk({tag, " R1 dev ack"}, ak, 0);
    tx_byte(a, ak);     chk({tag, " addr ack"}, ak, 0);
    tx_byte(d, ak);     chk({tag, " data ack"}, ak, 0);
    bus_stop();
    if (a >= 8'h80 && !wp) model[a] = d;
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_up();
    end
  end

  initial begin
    logic       ak;
    logic [7:0] b;
    string      tag;
    for (int i = 0; i < 256; i++) model[i] = img(i);
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; strap = 3'b101; wp = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 data line released in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R11 data line released after reset", sda_oe, 0);
    chk("R8 checksum flag after reset", csum_ok, 1);

    for (int v = 0; v < NVEC; v++) begin
      wp = VEC[v][18];
      if (VEC[v][17:16] == 2'd0) begin
        if (VEC[v][15:8] < 8'h80) tag = "R5 locked write";
        else if (wp) tag = "R6 protected write";
        else tag = "R4 upper write";
        byte_write(VEC[v][15:8], VEC[v][7:0], tag);
      end else begin
        rand_read(VEC[v][15:8], "R2 random read");
      end
      wp = 1'b0;
      chk("R8 checksum flag after vector", csum_ok, 1);
    end

    // R5 and R6: the ignored writes left the old bytes in place
    rand_read(8'h10, "R5 locked byte kept");
    rand_read(8'h20, "R6 protected lower byte kept");
    rand_read(8'hA0, "R6 protected upper byte kept");
    rand_read(8'h80, "R4 stored byte");

    // R7: reset image spot checks
    rand_read(8'h3F, "R7 checksum byte");
    chk("R7 checksum byte value", model[63], img(63));
    rand_read(8'h02, "R7 first formula byte");
    rand_read(8'h40, "R7 xor byte");
    rand_read(8'h7F, "R7 last lower byte");
    rand_read(8'hC5, "R7 upper blank byte");

    // R3: sequential read across the wrap
    read_setup(7'h55, 8'hFE, "R3");
    for (int k = 0; k < 4; k++) begin
      rx_byte(k != 3, b);
      chk("R3 sequential byte", b, model[(254 + k) % 256]);
    end
    bus_stop();
    chk("R10 released after stop", sda_oe, 0);

    // R9: second data byte refused, pointer one past the written byte
    bus_start();
    tx_byte(8'hAA, ak); chk("R9 dev ack", ak, 0);
    tx_byte(8'hC0, ak); chk("R9 addr ack", ak, 0);
    tx_byte(8'h11, ak); chk("R9 first data ack", ak, 0);
    tx_byte(8'h22, ak); chk("R9 second data nack", ak, 1);
    bus_stop();
    model[8'hC0] = 8'h11;
    bus_start();
    tx_byte(8'hAB, ak); chk("R9 current read dev ack", ak, 0);
    rx_byte(1'b0, b);
    bus_stop();
    chk("R9 current address read", b, model[8'hC1]);
    rand_read(8'hC0, "R9 first byte stored");

    // R1: wrong device address, then the same address after re-strapping
    bus_start();
    tx_byte(8'hA0, ak); chk("R1 mismatch nack", ak, 1);
    tx_byte(8'h00, ak); chk("R1 silent after mismatch", ak, 1);
    bus_stop();
    strap = 3'b000;
    read_setup(7'h50, 8'h00, "R1 new strap");
    rx_byte(1'b0, b);
    bus_stop();
    chk("R1 read via new strap", b, 8'h80);
    strap = 3'b101;

    chk("R8 checksum flag at end", csum_ok, 1);
    chk("R10 idle line at end", sda_oe, 0);
    done = 1'b1;
    finish_up();
  end

endmodule